// File: doc/BRIEF.md
# VLAN-Aware Transmit Frame Padder

This block sits in the transmit path of an Ethernet MAC, between the frame source and the line encoder. It takes a frame as a byte stream marked with start and end flags. It decides per frame whether the frame is tagged or untagged. It then enforces the matching length rules: short frames are extended with zero bytes when padding is enabled, and a CRC-32 frame check sequence is appended. Frames that are too long are flagged.

A frame counts as tagged in one of two ways. In the forced mode, every frame is tagged. In the matching mode, a frame is tagged only when its 16-bit type field equals a programmable value. The forced mode wins when both modes are set. A tagged frame is padded to 68 bytes rather than 64, so the 4-byte tag does not use up payload room. The mode inputs, the pad enable and the type value are captured on the first byte of each frame. Asserting the software reset input holds the whole block idle.

Top module: `vlan_tx_padder`

## Requirements
- R1: Each byte accepted (in_valid and in_ready both high at a clock edge) appears on out_data with out_valid high in the next cycle. The first byte of the frame carries out_sop.
- R2: With pad enable set, an untagged frame of fewer than 60 data bytes is followed by zero bytes up to 60 data bytes, then by the 4 check bytes, for 64 bytes in total.
- R3: With pad enable set, a tagged frame of fewer than 64 data bytes is followed by zero bytes up to 64 data bytes, then by the 4 check bytes, for 68 bytes in total.
- R4: In matching mode, a frame is tagged only if frame bytes 12 and 13 (byte 12 is the high byte) equal vlan_type. A frame that ends before byte 13 is untagged.
- R5: In forced mode, every frame is tagged whatever its type bytes. This holds also when matching mode is set at the same time.
- R6: After the data and pad bytes, the block sends the CRC-32 of all those bytes. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. It is sent least significant byte first. out_eop is high on the last check byte.
- R7: With pad enable clear, no pad bytes are inserted: a frame of N data bytes leaves as N+4 bytes.
- R8: If the frame length including the 4 check bytes exceeds 1518 (untagged) or 1522 (tagged), oversize is high for exactly the cycle of the final byte. The frame is still sent in full. oversize is never high in any other cycle.
- R9: pad_en, force_vlan, auto_vlan and vlan_type are taken from the cycle that accepts the first byte. Changes later in the frame do not affect that frame.
- R10: in_ready is low from the cycle after the last data byte is accepted until the cycle that presents the last check byte. That is one low cycle per generated pad or check byte.
- R11: While sw_rst is high, in_ready is low. From the cycle after sw_rst rises, out_valid is low. After sw_rst falls, the next frame is handled normally.
- R12: After rst, out_valid, out_sop, out_eop and oversize are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Level-held software reset |
| pad_en | input | 1 | Enable zero padding of short frames |
| force_vlan | input | 1 | Treat every frame as tagged |
| auto_vlan | input | 1 | Tag frames whose type field matches vlan_type |
| vlan_type | input | 16 | Type value that marks a tagged frame |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first of a frame |
| in_eop | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take an input byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First byte of an output frame |
| out_eop | output | 1 | Last byte (final check byte) of an output frame |
| out_data | output | 8 | Output byte |
| oversize | output | 1 | Frame exceeded its maximum length; valid with out_eop |

## Verification
The same short payload is sent with the type bytes matching, not matching, and ending before the type field. Each is sent under matching mode, forced mode and both modes together, so the 64-byte and 68-byte pad targets tell the tagged and untagged outcomes apart. Frames of exactly 60 and 64 data bytes, and frames one byte either side of each maximum, separate off-by-one errors in the pad stop and the oversize compare. A frame whose mode inputs flip mid-frame shows whether the settings are latched at the first byte. Random lengths, random payloads and random modes exercise the CRC over many byte patterns.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } vtp_state_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/vtp_classify.sv
module vtp_classify #(
  parameter int TYPE_OFS = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic        sop,
  input  logic [7:0]  data,
  input  logic        force_in,
  input  logic        auto_in,
  input  logic [15:0] type_in,
  output logic        vlan_nx,
  output logic        vlan_q
);
  localparam logic [3:0] POS_HI  = 4'(TYPE_OFS);
  localparam logic [3:0] POS_LO  = 4'(TYPE_OFS + 1);
  localparam logic [3:0] POS_MAX = 4'd15;

  logic [3:0]  pos_q, pos;
  logic [7:0]  hi_q;
  logic        frc_q, aut_q;
  logic [15:0] typ_q;

  assign pos = sop ? 4'd0 : pos_q;

  always_comb begin
    if (sop)                 vlan_nx = force_in;
    else if (pos_q == POS_LO) vlan_nx = frc_q | (aut_q & ({hi_q, data} == typ_q));
    else                     vlan_nx = vlan_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      hi_q   <= '0;
      frc_q  <= 1'b0;
      aut_q  <= 1'b0;
      typ_q  <= '0;
      vlan_q <= 1'b0;
    end else if (take) begin
      if (sop) begin
        frc_q <= force_in;
        aut_q <= auto_in;
        typ_q <= type_in;
      end
      pos_q  <= (pos == POS_MAX) ? POS_MAX : pos + 4'd1;
      if (pos == POS_HI) hi_q <= data;
      vlan_q <= vlan_nx;
    end
  end
endmodule

// File: rtl/vtp_len.sv
module vtp_len #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_nx,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_comb begin
    if (restart)              cnt_nx = CNT_W'(1);
    else if (cnt_q == CNT_TOP) cnt_nx = cnt_q;
    else                      cnt_nx = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/vtp_crc.sv
module vtp_crc (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        clear,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  import vtp_pkg::*;

  logic [31:0] base;
  assign base = clear ? 32'hFFFF_FFFF : crc_q;

  always_ff @(posedge clk) begin
    if (rst)     crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_step(base, din);
  end
endmodule

// File: rtl/vlan_tx_padder.sv
module vlan_tx_padder #(
  parameter int CNT_W     = 12,
  parameter int MIN_UNTAG = 64,
  parameter int MIN_VLAN  = 68,
  parameter int MAX_UNTAG = 1518,
  parameter int MAX_VLAN  = 1522
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sw_rst,
  input  logic        pad_en,
  input  logic        force_vlan,
  input  logic        auto_vlan,
  input  logic [15:0] vlan_type,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop,
  output logic [7:0]  out_data,
  output logic        oversize
);
  import vtp_pkg::*;

  localparam int FCS_N = 4;
  localparam int FCS_W = $clog2(FCS_N);
  localparam logic [FCS_W-1:0] FCS_LAST = FCS_W'(FCS_N - 1);
  localparam logic [CNT_W-1:0] TGT_U = CNT_W'(MIN_UNTAG - FCS_N);
  localparam logic [CNT_W-1:0] TGT_V = CNT_W'(MIN_VLAN - FCS_N);
  localparam logic [CNT_W-1:0] LIM_U = CNT_W'(MAX_UNTAG - FCS_N);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(MAX_VLAN - FCS_N);

  logic             rst_all;
  vtp_state_t       st_q;
  logic [FCS_W-1:0] fcs_idx_q;
  logic             pad_q, ovs_q;
  logic             take, in_pad, in_fcs, fcs_last;
  logic             pad_eff, vlan_nx, vlan_q;
  logic [CNT_W-1:0] cnt_nx, cnt_q;
  logic [CNT_W-1:0] tgt_end, tgt_pad, lim_end;
  logic [31:0]      crc_q;

  assign rst_all  = rst | sw_rst;
  assign in_ready = (st_q == ST_DATA) & ~rst_all;
  assign take     = in_valid & in_ready;
  assign in_pad   = (st_q == ST_PAD);
  assign in_fcs   = (st_q == ST_FCS);
  assign fcs_last = in_fcs & (fcs_idx_q == FCS_LAST);
  assign pad_eff  = in_sop ? pad_en : pad_q;
  assign tgt_end  = vlan_nx ? TGT_V : TGT_U;
  assign tgt_pad  = vlan_q  ? TGT_V : TGT_U;
  assign lim_end  = vlan_nx ? LIM_V : LIM_U;

  vtp_classify u_cls (
    .clk      (clk),
    .rst      (rst_all),
    .take     (take),
    .sop      (in_sop),
    .data     (in_data),
    .force_in (force_vlan),
    .auto_in  (auto_vlan),
    .type_in  (vlan_type),
    .vlan_nx  (vlan_nx),
    .vlan_q   (vlan_q)
  );

  vtp_len #(.CNT_W(CNT_W)) u_len (
    .clk     (clk),
    .rst     (rst_all),
    .step    (take | in_pad),
    .restart (take & in_sop),
    .cnt_nx  (cnt_nx),
    .cnt_q   (cnt_q)
  );

  vtp_crc u_crc (
    .clk   (clk),
    .rst   (rst_all),
    .en    (take | in_pad),
    .clear (take & in_sop),
    .din   (in_pad ? 8'h00 : in_data),
    .crc_q (crc_q)
  );

  // frame sequencing
  always_ff @(posedge clk) begin
    if (rst_all) begin
      st_q      <= ST_DATA;
      fcs_idx_q <= '0;
      pad_q     <= 1'b0;
      ovs_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_DATA: begin
          if (take && in_sop) pad_q <= pad_en;
          if (take && in_eop) begin
            ovs_q     <= (cnt_nx > lim_end);
            fcs_idx_q <= '0;
            if (pad_eff && (cnt_nx < tgt_end)) st_q <= ST_PAD;
            else                               st_q <= ST_FCS;
          end
        end
        ST_PAD: begin
          if (cnt_nx >= tgt_pad) st_q <= ST_FCS;
        end
        ST_FCS: begin
          fcs_idx_q <= fcs_idx_q + FCS_W'(1);
          if (fcs_idx_q == FCS_LAST) st_q <= ST_DATA;
        end
        default: st_q <= ST_DATA;
      endcase
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst_all) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
      oversize  <= 1'b0;
    end else begin
      out_valid <= take | in_pad | in_fcs;
      out_sop   <= take & in_sop;
      out_eop   <= fcs_last;
      oversize  <= fcs_last & ovs_q;
      if (take)        out_data <= in_data;
      else if (in_pad) out_data <= 8'h00;
      else             out_data <= ~crc_q[{fcs_idx_q, 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/vtp_checker.sv
module vtp_checker (
  input logic       clk,
  input logic       rst,
  input logic       sw_rst,
  input logic       in_valid,
  input logic       in_sop,
  input logic       in_eop,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_sop,
  input logic       out_eop,
  input logic [7:0] out_data,
  input logic       oversize
);
  logic take;
  assign take = in_valid & in_ready;

  p_pass_r1: assert property (@(posedge clk) disable iff (rst)
    take |=> (out_valid && out_data == $past(in_data)));

  p_sop_r1: assert property (@(posedge clk) disable iff (rst)
    (take && in_sop) |=> out_sop);

  p_eop_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_eop |-> out_valid);

  p_ovs_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    oversize |-> (out_valid && out_eop));

  p_ready_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (take && in_eop && !sw_rst) |=> !in_ready);

  p_swrst_ready_r11: assert property (@(posedge clk) disable iff (rst)
    sw_rst |-> !in_ready);

  p_swrst_out_r11: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> !out_valid);
endmodule

bind vlan_tx_padder vtp_checker u_vtp_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_rst    (sw_rst),
  .in_valid  (in_valid),
  .in_sop    (in_sop),
  .in_eop    (in_eop),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_data  (out_data),
  .oversize  (oversize)
);

// File: tb/sim_vlan_tx_padder.sv
`timescale 1ns/1ps
module sim_vlan_tx_padder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, sw_rst = 1'b0, pad_en = 1'b0, force_vlan = 1'b0, auto_vlan = 1'b0;
  logic [15:0] vlan_type = 16'h0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = 8'h0;
  logic in_ready, out_valid, out_sop, out_eop, oversize;
  logic [7:0] out_data;

  vlan_tx_padder u0 (.*);

  int checks = 0, errors = 0;
  logic [7:0] fb [0:2047];
  logic [7:0] eb [0:2047];
  logic [7:0] mb [0:2047];
  int  exp_n;
  bit  exp_ovs;
  int  mon_n = 0;
  bit  mon_done = 0, mon_ovs = 0;
  bit  stray_ovs = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (out_sop) mon_n = 0;
      if (mon_n < 2048) mb[mon_n] = out_data;
      mon_n++;
      if (out_eop) begin mon_done = 1; mon_ovs = oversize; end
    end
    if (!rst && oversize && !out_eop) stray_ovs = 1;
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, eb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build_exp(input int len, input bit pad, input bit frc, input bit aut, input logic [15:0] vt);
    bit vl;
    int tgt, n;
    logic [31:0] c;
    vl  = frc || (aut && len >= 14 && {fb[12], fb[13]} == vt);
    tgt = vl ? 64 : 60;
    for (int i = 0; i < len; i++) eb[i] = fb[i];
    n = len;
    if (pad) while (n < tgt) begin eb[n] = 8'h00; n++; end
    c = ref_crc(n);
    for (int k = 0; k < 4; k++) eb[n + k] = c[8*k +: 8];
    exp_n   = n + 4;
    exp_ovs = (len + 4) > (vl ? 1522 : 1518);
  endtask

  task automatic send(input int len, input bit pad, input bit frc, input bit aut,
                      input logic [15:0] vt, input bit flip, input string req);
    int low, t, bad, first_bad;
    build_exp(len, pad, frc, aut, vt);
    mon_done = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin pad_en = pad; force_vlan = frc; auto_vlan = aut; vlan_type = vt; end
      if (flip && i == 3) begin pad_en = ~pad; force_vlan = ~frc; auto_vlan = ~aut; vlan_type = ~vt; end
      in_valid = 1; in_data = fb[i]; in_sop = (i == 0); in_eop = (i == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    low = 0;
    while (!in_ready && low < 5000) begin low++; @(negedge clk); end
    t = 0;
    while (!mon_done && t < 100) begin t++; @(negedge clk); end
    chk(low == exp_n - len, "R10", {req, " ready-low cycles"}, low, exp_n - len);
    chk(mon_done && mon_n == exp_n, req, "frame length", mon_n, exp_n);
    bad = 0; first_bad = -1;
    for (int i = 0; i < exp_n && i < mon_n; i++)
      if (mb[i] !== eb[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (first_bad >= 0)
      chk(0, req, $sformatf("byte %0d value", first_bad), mb[first_bad], eb[first_bad]);
    else
      chk(1, req, "bytes", 0, 0);
    chk(mon_ovs == exp_ovs, "R8", {req, " oversize"}, mon_ovs, exp_ovs);
  endtask

  task automatic fill(input int len, input bit with_type, input logic [15:0] vt);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    if (with_type && len >= 14) begin fb[12] = vt[15:8]; fb[13] = vt[7:0]; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0 && out_sop == 0 && out_eop == 0 && oversize == 0,
        "R12", "reset state", {in_ready, out_valid, out_sop, out_eop, oversize}, 5'b10000);

    fill(20, 0, 16'h8100); send(20, 1, 0, 0, 16'h8100, 0, "R2 R1 R6 untagged pad");
    fill(20, 1, 16'h8100); send(20, 1, 0, 1, 16'h8100, 0, "R3 R4 match pad");
    fill(20, 0, 16'h8100); fb[12] = 8'h81; fb[13] = 8'h01;
    send(20, 1, 0, 1, 16'h8100, 0, "R4 mismatch");
    fill(13, 0, 16'h0000); send(13, 1, 0, 1, 16'h0000, 0, "R4 ends before type");
    fill(20, 0, 16'h88A8); fb[12] = 8'h08; fb[13] = 8'h00;
    send(20, 1, 1, 1, 16'h88A8, 0, "R5 forced over auto");
    fill(1, 0, 0);         send(1, 1, 1, 0, 16'h0, 0, "R5 R3 one-byte forced");
    fill(20, 1, 16'h8100); send(20, 0, 0, 1, 16'h8100, 0, "R7 pad off");
    fill(60, 0, 0);        send(60, 1, 0, 0, 16'h0, 0, "R2 exactly 60");
    fill(63, 0, 0);        send(63, 1, 1, 0, 16'h0, 0, "R3 63 tagged");
    fill(64, 0, 0);        send(64, 1, 1, 0, 16'h0, 0, "R3 exactly 64");
    fill(1514, 0, 0);      send(1514, 1, 0, 0, 16'h0, 0, "R8 untagged at max");
    fill(1515, 0, 0);      send(1515, 1, 0, 0, 16'h0, 0, "R8 untagged over max");
    fill(1518, 0, 0);      send(1518, 1, 1, 0, 16'h0, 0, "R8 tagged at max");
    fill(1519, 1, 16'h9100); send(1519, 1, 0, 1, 16'h9100, 0, "R8 tagged over max");
    fill(20, 0, 16'h8100); send(20, 1, 0, 0, 16'h8100, 1, "R9 mid-frame change");
    fill(20, 1, 16'h8100); send(20, 1, 0, 1, 16'h8100, 1, "R9 mid-frame change tagged");

    // software reset in the middle of a frame
    fill(30, 0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = fb[i]; in_sop = (i == 0); in_eop = 0;
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; sw_rst = 1;
    @(negedge clk);
    chk(in_ready == 0, "R11", "ready while held", in_ready, 0);
    @(negedge clk);
    chk(out_valid == 0, "R11", "out_valid while held", out_valid, 0);
    @(negedge clk);
    sw_rst = 0;
    fill(25, 0, 0); send(25, 1, 0, 0, 16'h0, 0, "R11 after release");

    for (int f = 0; f < 30; f++) begin
      int len;
      bit p, fr, au, wt;
      logic [15:0] vt;
      len = 1 + int'($urandom % 200);
      p = 1'($urandom); fr = ($urandom % 4) == 0; au = 1'($urandom); wt = 1'($urandom);
      vt = 16'($urandom);
      fill(len, wt, vt);
      send(len, p, fr, au, vt, 0, "R6 random");
    end

    chk(stray_ovs == 0, "R8", "oversize outside last byte", stray_ovs, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule